// File: doc/BRIEF.md
# Single-Bit Register with Selectable Asynchronous Control

This block is one storage bit for a programmable logic element. On each rising clock edge it captures a synchronous data input. Two active-low control lines, `ctl_a_n` and `ctl_b_n`, act on the bit without waiting for the clock. What they do is fixed when the block is built, by the `MODE` parameter.

The control lines can give an asynchronous clear, an asynchronous preset, or both. They can also give an asynchronous load of a second data input (`async_d`), alone or together with a clear or a preset. A control that the chosen mode does not use behaves as if tied high, so it never acts.

A synchronous active-low reset clears the bit on a clock edge. This reset has lower priority than every asynchronous control.

The mode encoding follows the order below:

| MODE | Behaviour |
|------|-----------|
| 0 | Clear only |
| 1 | Preset only |
| 2 | Clear plus preset |
| 3 | Load plus clear |
| 4 | Load plus preset |
| 5 | Load alone |

In modes 0 and 1 the parameter `CLR_LINE` chooses the control line.

Top module: `regcell_top`

## Requirements
- R1: With `rst_n` low and no asynchronous control active, a rising clock edge sets `q` to 0.
- R2: With `rst_n` high and no asynchronous control active, `q` takes the value of `d` at each rising clock edge.
- R3: In MODE 0 the clear comes from `ctl_a_n` when `CLR_LINE`=0, or from `ctl_b_n` when `CLR_LINE`=1. Driving that line low forces `q` to 0 at once. The other line has no effect on `q`.
- R4: In MODE 1 the preset comes from `ctl_a_n` when `CLR_LINE`=0. Driving it low forces `q` to 1 at once. `ctl_b_n` has no effect on `q`.
- R5: In MODE 2, `ctl_a_n` low clears `q` and `ctl_b_n` low presets `q`. When both are low, `q` is 0.
- R6: In MODE 3, `ctl_a_n` going low copies `async_d` into `q` at once, and `ctl_b_n` low clears `q`. When both are low, `q` is 0.
- R7: In MODE 4, `ctl_a_n` going low copies `async_d` into `q` at once, and `ctl_b_n` low presets `q`. When both are low, `q` is 1.
- R8: In MODE 5, `ctl_a_n` going low copies `async_d` into `q` at once, and `ctl_b_n` has no effect on `q`.
- R9: Each asynchronous clear, preset and load changes `q` before the next rising clock edge arrives.
- R10: While an asynchronous control stays active, a rising clock edge does not load `d`.
- R11: Releasing an asynchronous control does not change `q`. The next rising edge with no control active captures `d` again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_a_n | input | 1 | First active-low control line |
| ctl_b_n | input | 1 | Second active-low control line |
| async_d | input | 1 | Value copied in by an asynchronous load |
| d | input | 1 | Synchronous data input |
| q | output | 1 | Register output |

## Verification
All seven build variants are run side by side on the same stimulus: the six modes, plus clear-only with `CLR_LINE`=1.

Each control is driven when `q` already holds the opposite of the forced value, so every forced change is visible:
- A design that waits for a clock before acting shows the old `q` right after the control falls.
- A design that swaps the priority between clear or preset and load shows `async_d` instead of the forced constant when both lines are low.
- A design that decodes an unused line lets `q` move in modes 1, 5 or the alternate clear variant.

Clock edges are also applied while a load is held and after it is released. A design that lets `d` through during a held control fails there, and so does one that disturbs `q` on release.

// File: rtl/regcell_pkg.sv
// Package: shared encoding of the asynchronous control modes.
// Assumes: mode values are fixed at build time and taken in this order.
package regcell_pkg;

    typedef enum logic [2:0] {
        AM_CLR     = 3'd0,
        AM_PRE     = 3'd1,
        AM_CLR_PRE = 3'd2,
        AM_LD_CLR  = 3'd3,
        AM_LD_PRE  = 3'd4,
        AM_LD      = 3'd5
    } amode_e;

endpackage

// File: rtl/regcell_ctl_decode.sv
// Module: regcell_ctl_decode
// Turns the two raw control lines into separate clear, preset and load
// strobes for the selected mode. A strobe that the mode does not use is
// held high (inactive).
// Assumes: MODE and CLR_LINE are static. The inputs are active-low.
module regcell_ctl_decode
    import regcell_pkg::*;
#(
    parameter amode_e MODE     = AM_CLR,
    parameter int     CLR_LINE = 0
) (
    input  logic ctl_a_n,
    input  logic ctl_b_n,
    output logic clr_n,
    output logic pre_n,
    output logic ld_n
);

    localparam bit USE_B = (CLR_LINE != 0);

    generate
        if (MODE == AM_CLR) begin : g_clr
            // Purpose: route the chosen line to clear only.
            always_comb begin
                clr_n = USE_B ? ctl_b_n : ctl_a_n;
                pre_n = 1'b1;
                ld_n  = 1'b1;
            end
        end else if (MODE == AM_PRE) begin : g_pre
            // Purpose: route the chosen line to preset only.
            always_comb begin
                clr_n = 1'b1;
                pre_n = USE_B ? ctl_b_n : ctl_a_n;
                ld_n  = 1'b1;
            end
        end else if (MODE == AM_CLR_PRE) begin : g_clr_pre
            // Purpose: line A clears, line B presets.
            always_comb begin
                clr_n = ctl_a_n;
                pre_n = ctl_b_n;
                ld_n  = 1'b1;
            end
        end else if (MODE == AM_LD_CLR) begin : g_ld_clr
            // Purpose: line A loads, line B clears.
            always_comb begin
                clr_n = ctl_b_n;
                pre_n = 1'b1;
                ld_n  = ctl_a_n;
            end
        end else if (MODE == AM_LD_PRE) begin : g_ld_pre
            // Purpose: line A loads, line B presets.
            always_comb begin
                clr_n = 1'b1;
                pre_n = ctl_b_n;
                ld_n  = ctl_a_n;
            end
        end else begin : g_ld
            // Purpose: line A loads, line B is not used.
            always_comb begin
                clr_n = 1'b1;
                pre_n = 1'b1;
                ld_n  = ctl_a_n;
            end
        end
    endgenerate

endmodule

// File: rtl/regcell_store.sv
// Module: regcell_store
// One flip-flop with three asynchronous controls and a synchronous reset.
// Priority, highest first: clear, preset, load, reset, then capture of d.
// Assumes: the strobes come from regcell_ctl_decode and are active-low.
module regcell_store (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    input  logic pre_n,
    input  logic ld_n,
    input  logic ld_val,
    input  logic d,
    output logic q
);

    // Purpose: the storage bit, with its asynchronous override chain.
    always_ff @(posedge clk or negedge clr_n or negedge pre_n or negedge ld_n) begin
        if (!clr_n) begin
            q <= 1'b0;
        end else if (!pre_n) begin
            q <= 1'b1;
        end else if (!ld_n) begin
            q <= ld_val;
        end else if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= d;
        end
    end

    // R2 R11
    capture_d_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && pre_n && ld_n) |=> (!clr_n || !pre_n || !ld_n || q == $past(d)));

    // R10
    clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n) |-> (q == 1'b0));

endmodule

// File: rtl/regcell_top.sv
// Module: regcell_top
// Single-bit register cell whose two active-low control lines take on
// clear, preset or asynchronous-load roles as fixed by MODE.
// Assumes: MODE is 0..5 (see regcell_pkg). CLR_LINE picks the line for the
// single-control modes.
module regcell_top
    import regcell_pkg::*;
#(
    parameter amode_e MODE     = AM_CLR,
    parameter int     CLR_LINE = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_a_n,
    input  logic ctl_b_n,
    input  logic async_d,
    input  logic d,
    output logic q
);

    logic clr_n;
    logic pre_n;
    logic ld_n;

    regcell_ctl_decode #(
        .MODE     (MODE),
        .CLR_LINE (CLR_LINE)
    ) u_dec (
        .ctl_a_n (ctl_a_n),
        .ctl_b_n (ctl_b_n),
        .clr_n   (clr_n),
        .pre_n   (pre_n),
        .ld_n    (ld_n)
    );

    regcell_store u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_n  (clr_n),
        .pre_n  (pre_n),
        .ld_n   (ld_n),
        .ld_val (async_d),
        .d      (d),
        .q      (q)
    );

    generate
        if (MODE == AM_CLR) begin : g_chk_clr
            // R3
            clr_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!((CLR_LINE != 0) ? ctl_b_n : ctl_a_n)) |-> (q == 1'b0));
        end else if (MODE == AM_PRE) begin : g_chk_pre
            // R4
            pre_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!((CLR_LINE != 0) ? ctl_b_n : ctl_a_n)) |-> (q == 1'b1));
        end else if (MODE == AM_CLR_PRE) begin : g_chk_cp
            // R5
            cp_clr_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!ctl_a_n) |-> (q == 1'b0));
            // R5
            cp_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(ctl_a_n) && ctl_a_n && !ctl_b_n) |-> (q == 1'b1));
        end else if (MODE == AM_LD_CLR) begin : g_chk_lc
            // R6
            lc_clr_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!ctl_b_n) |-> (q == 1'b0));
            // R6
            lc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ctl_b_n && !ctl_a_n) |=> (!ctl_b_n || q == $past(async_d)));
        end else if (MODE == AM_LD_PRE) begin : g_chk_lp
            // R7
            lp_pre_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!ctl_b_n) |-> (q == 1'b1));
            // R7
            lp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ctl_b_n && !ctl_a_n) |=> (!ctl_b_n || q == $past(async_d)));
        end else begin : g_chk_ld
            // R8
            ld_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!ctl_a_n) |=> (q == $past(async_d)));
        end
    endgenerate

endmodule

// File: tb/tb_regcell_top.sv
`timescale 1ns/1ps
// Bench: drives seven build variants of regcell_top with shared stimulus.
// Lane n uses MODE n; lane 6 is MODE 0 with CLR_LINE=1.
// The driver pushes expected q values into a queue; the monitor pops and
// compares them.
module tb_regcell_top;
    import regcell_pkg::*;

    localparam int LANES = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_a_n = 1'b1;
    logic ctl_b_n = 1'b1;
    logic async_d = 1'b0;
    logic d = 1'b1;
    logic [LANES-1:0] qv;

    always #2 clk = ~clk;

    for (genvar m = 0; m < LANES; m++) begin : g_lane
        regcell_top #(
            .MODE     (amode_e'((m < 6) ? m : 0)),
            .CLR_LINE ((m == 6) ? 1 : 0)
        ) dut (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctl_a_n (ctl_a_n),
            .ctl_b_n (ctl_b_n),
            .async_d (async_d),
            .d       (d),
            .q       (qv[m])
        );
    end

    typedef struct {
        int    lane;
        logic  exp;
        string tag;
    } item_t;

    item_t sb[$];
    event  sample_ev;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    // Monitor: pop every queued item and compare it with the lane output.
    always @(sample_ev) begin
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_chk++;
            if (qv[it.lane] !== it.exp) begin
                n_fail++;
                $display("FAIL %s lane %0d: q=%b expected %b", it.tag, it.lane,
                         qv[it.lane], it.exp);
            end
        end
    end

    task automatic expect_all(input logic [LANES-1:0] e, input string tag);
        for (int i = 0; i < LANES; i++) begin
            item_t it;
            it.lane = i;
            it.exp  = e[i];
            it.tag  = tag;
            sb.push_back(it);
        end
        -> sample_ev;
        #0.5;
    endtask

    task automatic drive(input logic a, input logic b, input logic ad, input logic dd);
        @(negedge clk);
        ctl_a_n = a;
        ctl_b_n = b;
        async_d = ad;
        d       = dd;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        tick();
        tick();
        expect_all(7'b0000000, "R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        expect_all(7'b1111111, "R2 capture 1");
        drive(1, 1, 0, 0);
        tick();
        expect_all(7'b0000000, "R2 capture 0");
        drive(1, 1, 0, 1);
        tick();
        expect_all(7'b1111111, "R2 capture 1 again");
        // Line A low, async_d=0: modes react at once (R3 R4 R5 R6 R7 R8 R9).
        drive(0, 1, 0, 1);
        expect_all(7'b1000010, "R9 line A immediate");
        tick();
        expect_all(7'b1000010, "R10 held control blocks d");
        drive(1, 1, 0, 1);
        expect_all(7'b1000010, "R11 release keeps q");
        tick();
        expect_all(7'b1111111, "R11 capture after release");
        drive(1, 1, 0, 0);
        tick();
        expect_all(7'b0000000, "R2 clear to 0");
        // Line B low from q=0 (R4 R5 R7 R8).
        drive(1, 0, 1, 0);
        expect_all(7'b0010100, "R5 R7 line B preset, R4 R8 no effect");
        drive(1, 1, 1, 1);
        tick();
        expect_all(7'b1111111, "R11 recover");
        // Line B low from q=1 (R3 R6).
        drive(1, 0, 0, 1);
        expect_all(7'b0110111, "R3 R6 line B clear");
        drive(1, 1, 0, 1);
        tick();
        expect_all(7'b1111111, "R11 recover");
        // Both lines low, async_d=0, from q=1.
        drive(0, 0, 0, 1);
        expect_all(7'b0010010, "R5 R6 R7 both low from 1");
        drive(1, 1, 0, 0);
        tick();
        expect_all(7'b0000000, "R2 to 0");
        // Both lines low, async_d=1, from q=0.
        drive(0, 0, 1, 0);
        expect_all(7'b0110010, "R4 R6 R7 R8 both low from 0");
        drive(1, 1, 1, 1);
        tick();
        expect_all(7'b1111111, "R11 recover");
        @(negedge clk);
        rst_n = 1'b0;
        tick();
        expect_all(7'b0000000, "R1 reset again");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule